// File: doc/BRIEF.md
# Debug Run-Control Register Block

This block is the register front end of a debug module that serves one hart. A debugger issues register reads and writes over a valid/ready request channel. Each request carries a 32-bit register address, 32 bits of write data and a 2-bit operation code. Every accepted request gets exactly one answer on a valid/ready response channel. The answer carries 32 bits of data and a 2-bit result code: success, failure or busy.

The block owns the run-control register. That register drives the halt request, the resume request and the non-debug-module reset toward the core. The block also assembles a read-only status word on the fly from the core's halted, running, resume-acknowledge and have-reset indications. Any access to an abstract-command register (the data word, the command status word and the command word) goes out through a narrow forwarding port to a separate abstract engine. A busy indication from that engine turns accesses to the data and command words away with a busy result.

Only one request is in flight at a time. A new request is accepted only once the previous response has been taken.

Top module: `dbg_runctl_top`

## Requirements
- R1: `reqReady` is high exactly when no response is pending. A request is accepted on a clock edge where `reqValid` and `reqReady` are both high, and `rspValid` rises on that same edge. `rspValid`, `rspData` and `rspOp` then hold steady until an edge where `rspReady` is high, and `rspValid` falls on that edge. Result codes are SUCCESS=0, FAILED=1 and BUSY=2.
- R2: Request op codes are NOP=0, READ=1, WRITE=2; code 3 is invalid. A NOP returns SUCCESS with zero data and changes nothing. An invalid op returns FAILED with zero data and changes nothing, whatever its address.
- R3: The run-control register is at address 0x10. Bit 31 is the halt request and drives `haltReq`. Bit 1 is the non-debug-module reset and drives `ndmReset`. Bit 0 is the module-active flag. Reserved bits 29:2 read as zero and ignore writes. A write returns SUCCESS with zero data, and a read returns the register contents captured at acceptance.
- R4: A write with bit 0 clear clears the halt, reset and resume bits along with the active flag, whatever the other written bits hold. While the active flag is 0, `haltReq`, `resumeReq` and `ndmReset` stay low.
- R5: A write to 0x10 with bits 30 and 0 set raises `resumeReq`, and bit 30 reads back as 1 while the request is pending. `resumeReq` falls on the first edge that samples `coreResumeAck` high, unless that same edge accepts another such write. Writing 0 to bit 30 does not withdraw a pending request.
- R6: The status register is at 0x11 and is read-only. Bits 11 and 10 both equal `coreRunning`. Bits 9 and 8 both equal `coreHalted`. Bits 19 and 18 both equal `coreHaveReset`. Bits 17 and 16 both equal `coreResumeAck`. Bits 3:0 read as 2, and every other bit reads 0. The core inputs are sampled at acceptance. A write returns SUCCESS and changes nothing.
- R7: A READ or WRITE to any address outside 0x04, 0x10, 0x11, 0x12, 0x16 and 0x17 returns FAILED with zero data and changes no state.
- R8: The hart information register at 0x12 reads as zero with SUCCESS. A write to it returns SUCCESS and changes nothing.
- R9: A READ or WRITE to 0x04, 0x16 or 0x17 that is not refused as busy asserts `absAccValid` for exactly the accepting cycle. In that cycle `absAccSel` is 0 for 0x04, 1 for 0x16 and 2 for 0x17, and `absAccWrite` is 1 for a WRITE. A READ returns the `absRdata` value sampled at acceptance; a WRITE returns zero data. Both return SUCCESS.
- R10: While `absBusy` is high, a READ or WRITE to 0x04 or 0x17 returns BUSY with zero data and is not forwarded. An access to 0x16 is still forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be accepted |
| reqAddr | input | 32 | Target register address |
| reqData | input | 32 | Write data |
| reqOp | input | 2 | Operation code |
| rspValid | output | 1 | Response pending |
| rspReady | input | 1 | Debugger takes the response |
| rspData | output | 32 | Response data |
| rspOp | output | 2 | Result code |
| coreHalted | input | 1 | Hart is halted |
| coreRunning | input | 1 | Hart is running |
| coreResumeAck | input | 1 | Hart acknowledges resume |
| coreHaveReset | input | 1 | Hart has been reset |
| haltReq | output | 1 | Halt request to the hart |
| resumeReq | output | 1 | Resume request to the hart |
| ndmReset | output | 1 | Reset of the system outside the debug module |
| absBusy | input | 1 | Abstract engine is executing |
| absRdata | input | 32 | Read data from the abstract engine |
| absAccValid | output | 1 | Forwarded access strobe |
| absAccSel | output | 2 | Forwarded register select |
| absAccWrite | output | 1 | Forwarded access is a write |
| absAccWdata | output | 32 | Forwarded write data |

## Verification
Two situations are the hardest to reach from the ports. One is a pending resume request that meets the core's acknowledge. The other is an abstract-engine access that arrives while the engine reports busy. The stimulus covers the first by writing the resume bit, holding the acknowledge low across a read that shows the request still pending, and then pulsing the acknowledge for one cycle. It covers the second by raising the busy input across reads and writes to all three forwarded addresses, so that refusal and forwarding are seen side by side. A behavioural model runs in step with the design and compares every output on every clock. Directed checks also compare each response against values written out by hand.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;

  localparam logic [ADDR_W-1:0] ADDR_DATA0   = 32'h04;
  localparam logic [ADDR_W-1:0] ADDR_CTL     = 32'h10;
  localparam logic [ADDR_W-1:0] ADDR_STAT    = 32'h11;
  localparam logic [ADDR_W-1:0] ADDR_HINFO   = 32'h12;
  localparam logic [ADDR_W-1:0] ADDR_CMDSTAT = 32'h16;
  localparam logic [ADDR_W-1:0] ADDR_CMD     = 32'h17;

  localparam int CTL_HALT_BIT   = 31;
  localparam int CTL_RESUME_BIT = 30;
  localparam int CTL_NDM_BIT    = 1;
  localparam int CTL_ACT_BIT    = 0;

  typedef enum logic [1:0] {OP_NOP = 2'd0, OP_READ = 2'd1, OP_WRITE = 2'd2, OP_BAD = 2'd3} reqOp_e;
  typedef enum logic [1:0] {RSP_SUCCESS = 2'd0, RSP_FAILED = 2'd1, RSP_BUSY = 2'd2} rspCode_e;
  typedef enum logic [1:0] {SRC_ZERO, SRC_CTL, SRC_STAT, SRC_ABS} rspSrc_e;
  typedef enum logic [1:0] {ABS_DATA0 = 2'd0, ABS_CMDSTAT = 2'd1, ABS_CMD = 2'd2} absSel_e;

  typedef struct packed {
    logic     load;
    logic     ctlWrite;
    rspCode_e code;
    rspSrc_e  src;
  } strobes_t;
endpackage

// File: rtl/dbg_runctl_ctrl.sv
module dbg_runctl_ctrl
  import dbg_runctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqOp,
  input  logic              rspReady,
  input  logic              absBusy,
  output logic              reqReady,
  output logic              rspValid,
  output logic              absAccValid,
  output logic [1:0]        absAccSel,
  output logic              absAccWrite,
  output strobes_t          stb
);
  logic     pend;
  logic     accept;
  logic     isWr;
  logic     fwd;
  logic     ctlWr;
  rspCode_e code;
  rspSrc_e  src;
  absSel_e  sel;

  assign accept = reqValid && !pend;
  assign isWr   = (reqOp == OP_WRITE);

  always_comb begin
    code  = RSP_SUCCESS;
    src   = SRC_ZERO;
    ctlWr = 1'b0;
    fwd   = 1'b0;
    sel   = ABS_DATA0;
    case (reqOp)
      OP_NOP: code = RSP_SUCCESS;
      OP_READ, OP_WRITE: begin
        case (reqAddr)
          ADDR_CTL: begin
            ctlWr = isWr;
            if (!isWr) src = SRC_CTL;
          end
          ADDR_STAT: begin
            if (!isWr) src = SRC_STAT;
          end
          ADDR_HINFO: src = SRC_ZERO;
          ADDR_DATA0, ADDR_CMD: begin
            if (absBusy) begin
              code = RSP_BUSY;
            end else begin
              fwd = 1'b1;
              if (!isWr) src = SRC_ABS;
            end
            sel = (reqAddr == ADDR_CMD) ? ABS_CMD : ABS_DATA0;
          end
          ADDR_CMDSTAT: begin
            fwd = 1'b1;
            sel = ABS_CMDSTAT;
            if (!isWr) src = SRC_ABS;
          end
          default: code = RSP_FAILED;
        endcase
      end
      default: code = RSP_FAILED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 pend <= 1'b0;
    else if (accept)           pend <= 1'b1;
    else if (pend && rspReady) pend <= 1'b0;
  end

  assign reqReady     = !pend;
  assign rspValid     = pend;
  assign absAccValid  = accept && fwd;
  assign absAccSel    = sel;
  assign absAccWrite  = isWr;
  assign stb.load     = accept;
  assign stb.ctlWrite = accept && ctlWr;
  assign stb.code     = code;
  assign stb.src      = src;

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid); // R1
  AST_FWD_THEN_RSP: assert property (@(posedge clk) disable iff (!rstN)
    absAccValid |=> rspValid); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    absBusy && absAccValid |-> absAccSel == ABS_CMDSTAT); // R10
endmodule

// File: rtl/dbg_runctl_dp.sv
module dbg_runctl_dp
  import dbg_runctl_pkg::*;
#(
  parameter logic [3:0] VERSION = 4'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [3:0]        ctlWdata,
  input  logic              coreHalted,
  input  logic              coreRunning,
  input  logic              coreResumeAck,
  input  logic              coreHaveReset,
  input  logic [DATA_W-1:0] absRdata,
  output logic [DATA_W-1:0] rspData,
  output logic [1:0]        rspOp,
  output logic              haltReq,
  output logic              resumeReq,
  output logic              ndmReset
);
  logic dmActive, haltBit, ndmBit, resumePend;
  logic wHalt, wResume, wNdm, wAct;
  logic [DATA_W-1:0] ctlView, statView, rspNext;

  assign {wHalt, wResume, wNdm, wAct} = ctlWdata;

  always_comb begin
    ctlView = '0;
    ctlView[CTL_HALT_BIT]   = haltBit;
    ctlView[CTL_RESUME_BIT] = resumePend;
    ctlView[CTL_NDM_BIT]    = ndmBit;
    ctlView[CTL_ACT_BIT]    = dmActive;
  end

  always_comb begin
    statView = '0;
    statView[3:0] = VERSION;
    statView[9]   = coreHalted;
    statView[8]   = coreHalted;
    statView[11]  = coreRunning;
    statView[10]  = coreRunning;
    statView[17]  = coreResumeAck;
    statView[16]  = coreResumeAck;
    statView[19]  = coreHaveReset;
    statView[18]  = coreHaveReset;
  end

  always_comb begin
    case (stb.src)
      SRC_CTL:  rspNext = ctlView;
      SRC_STAT: rspNext = statView;
      SRC_ABS:  rspNext = absRdata;
      default:  rspNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmActive   <= 1'b0;
      haltBit    <= 1'b0;
      ndmBit     <= 1'b0;
      resumePend <= 1'b0;
    end else begin
      if (resumePend && coreResumeAck) resumePend <= 1'b0;
      if (stb.ctlWrite) begin
        dmActive <= wAct;
        if (wAct) begin
          haltBit <= wHalt;
          ndmBit  <= wNdm;
          if (wResume) resumePend <= 1'b1;
        end else begin
          haltBit    <= 1'b0;
          ndmBit     <= 1'b0;
          resumePend <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspData <= '0;
      rspOp   <= RSP_SUCCESS;
    end else if (stb.load) begin
      rspData <= rspNext;
      rspOp   <= stb.code;
    end
  end

  assign haltReq   = haltBit;
  assign resumeReq = resumePend;
  assign ndmReset  = ndmBit;

  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !dmActive |-> !haltBit && !resumePend && !ndmBit); // R4
  AST_RESUME_RETIRES: assert property (@(posedge clk) disable iff (!rstN)
    resumePend && coreResumeAck && !stb.ctlWrite |=> !resumePend); // R5
  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(rspData) && $stable(rspOp)); // R1
endmodule

// File: rtl/dbg_runctl_top.sv
module dbg_runctl_top
  import dbg_runctl_pkg::*;
#(
  parameter logic [3:0] VERSION = 4'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [1:0]        reqOp,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [DATA_W-1:0] rspData,
  output logic [1:0]        rspOp,
  input  logic              coreHalted,
  input  logic              coreRunning,
  input  logic              coreResumeAck,
  input  logic              coreHaveReset,
  output logic              haltReq,
  output logic              resumeReq,
  output logic              ndmReset,
  input  logic              absBusy,
  input  logic [DATA_W-1:0] absRdata,
  output logic              absAccValid,
  output logic [1:0]        absAccSel,
  output logic              absAccWrite,
  output logic [DATA_W-1:0] absAccWdata
);
  strobes_t stb;

  dbg_runctl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqOp(reqOp),
    .rspReady(rspReady), .absBusy(absBusy), .reqReady(reqReady), .rspValid(rspValid),
    .absAccValid(absAccValid), .absAccSel(absAccSel), .absAccWrite(absAccWrite), .stb(stb)
  );

  dbg_runctl_dp #(.VERSION(VERSION)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .ctlWdata({reqData[CTL_HALT_BIT], reqData[CTL_RESUME_BIT], reqData[CTL_NDM_BIT], reqData[CTL_ACT_BIT]}),
    .coreHalted(coreHalted), .coreRunning(coreRunning), .coreResumeAck(coreResumeAck),
    .coreHaveReset(coreHaveReset), .absRdata(absRdata), .rspData(rspData), .rspOp(rspOp),
    .haltReq(haltReq), .resumeReq(resumeReq), .ndmReset(ndmReset)
  );

  assign absAccWdata = reqData;
endmodule

// File: tb/dbg_runctl_top_bench.sv
`timescale 1ns/1ps
module dbg_runctl_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, rspReady = 1'b0;
  logic [31:0] reqAddr = '0, reqData = '0, absRdata = '0;
  logic [1:0] reqOp = '0;
  logic coreHalted = 1'b0, coreRunning = 1'b0, coreResumeAck = 1'b0, coreHaveReset = 1'b0;
  logic absBusy = 1'b0;
  logic reqReady, rspValid, haltReq, resumeReq, ndmReset, absAccValid, absAccWrite;
  logic [31:0] rspData, absAccWdata;
  logic [1:0] rspOp, absAccSel;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dbg_runctl_top u_dbg_runctl_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqData(reqData), .reqOp(reqOp), .rspValid(rspValid), .rspReady(rspReady),
    .rspData(rspData), .rspOp(rspOp), .coreHalted(coreHalted), .coreRunning(coreRunning),
    .coreResumeAck(coreResumeAck), .coreHaveReset(coreHaveReset), .haltReq(haltReq),
    .resumeReq(resumeReq), .ndmReset(ndmReset), .absBusy(absBusy), .absRdata(absRdata),
    .absAccValid(absAccValid), .absAccSel(absAccSel), .absAccWrite(absAccWrite),
    .absAccWdata(absAccWdata)
  );

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic mPend = 1'b0, mAct = 1'b0, mHalt = 1'b0, mNdm = 1'b0, mRes = 1'b0;
  logic [1:0] mCode = '0;
  logic [31:0] mData = '0;

  function automatic logic [33:0] refResp(input logic [1:0] op, input logic [31:0] addr);
    logic [31:0] d;
    d = '0;
    if (op == 2'd0) return {2'd0, 32'd0};
    if (op == 2'd3) return {2'd1, 32'd0};
    case (addr)
      32'h10: begin
        if (op == 2'd1) begin
          d[31] = mHalt; d[30] = mRes; d[1] = mNdm; d[0] = mAct;
        end
        return {2'd0, d};
      end
      32'h11: begin
        if (op == 2'd1) begin
          d[11] = coreRunning; d[10] = coreRunning;
          d[9] = coreHalted; d[8] = coreHalted;
          d[19] = coreHaveReset; d[18] = coreHaveReset;
          d[17] = coreResumeAck; d[16] = coreResumeAck;
          d[3:0] = 4'd2;
        end
        return {2'd0, d};
      end
      32'h12: return {2'd0, 32'd0};
      32'h04, 32'h17: begin
        if (absBusy) return {2'd2, 32'd0};
        return {2'd0, (op == 2'd1) ? absRdata : 32'd0};
      end
      32'h16: return {2'd0, (op == 2'd1) ? absRdata : 32'd0};
      default: return {2'd1, 32'd0};
    endcase
  endfunction

  always @(posedge clk) begin
    logic [33:0] r;
    if (!rstN) begin
      mPend <= 1'b0; mAct <= 1'b0; mHalt <= 1'b0; mNdm <= 1'b0; mRes <= 1'b0;
      mCode <= '0; mData <= '0;
    end else begin
      if (mPend && rspReady) mPend <= 1'b0;
      if (mRes && coreResumeAck) mRes <= 1'b0;
      if (reqValid && !mPend) begin
        r = refResp(reqOp, reqAddr);
        mPend <= 1'b1;
        mCode <= r[33:32];
        mData <= r[31:0];
        if (reqOp == 2'd2 && reqAddr == 32'h10) begin
          mAct <= reqData[0];
          if (reqData[0]) begin
            mHalt <= reqData[31];
            mNdm  <= reqData[1];
            if (reqData[30]) mRes <= 1'b1;
          end else begin
            mHalt <= 1'b0; mNdm <= 1'b0; mRes <= 1'b0;
          end
        end
      end
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    logic expFwd;
    if (rstN) begin
      expFwd = reqValid && !mPend && (reqOp == 2'd1 || reqOp == 2'd2) &&
               (reqAddr == 32'h16 || ((reqAddr == 32'h04 || reqAddr == 32'h17) && !absBusy));
      check(reqReady == !mPend, "R1 reqReady", {31'd0, reqReady}, {31'd0, !mPend});
      check(rspValid == mPend, "R1 rspValid", {31'd0, rspValid}, {31'd0, mPend});
      if (mPend) begin
        check(rspOp == mCode, "R1/R2/R7 rspOp", {30'd0, rspOp}, {30'd0, mCode});
        check(rspData == mData, "R3/R6/R9 rspData", rspData, mData);
      end
      check(haltReq == mHalt, "R3 haltReq", {31'd0, haltReq}, {31'd0, mHalt});
      check(ndmReset == mNdm, "R3 ndmReset", {31'd0, ndmReset}, {31'd0, mNdm});
      check(resumeReq == mRes, "R5 resumeReq", {31'd0, resumeReq}, {31'd0, mRes});
      check(absAccValid == expFwd, "R9/R10 absAccValid", {31'd0, absAccValid}, {31'd0, expFwd});
      if (expFwd) begin
        check(absAccSel == (reqAddr == 32'h04 ? 2'd0 : reqAddr == 32'h16 ? 2'd1 : 2'd2),
              "R9 absAccSel", {30'd0, absAccSel}, reqAddr);
        check(absAccWrite == (reqOp == 2'd2), "R9 absAccWrite", {31'd0, absAccWrite}, {30'd0, reqOp});
        check(absAccWdata == reqData, "R9 absAccWdata", absAccWdata, reqData);
      end
    end
  end

  // one request, directed response check, response held for hold cycles
  task automatic xfer(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] data,
                      input logic [1:0] expCode, input logic [31:0] expData, input string tag,
                      input int hold);
    @(posedge clk); #2;
    reqValid = 1'b1; reqOp = op; reqAddr = addr; reqData = data;
    @(posedge clk); #2;
    reqValid = 1'b0; reqOp = 2'd0;
    @(negedge clk);
    check(rspValid == 1'b1, {tag, " response present"}, {31'd0, rspValid}, 32'd1);
    check(rspOp == expCode, {tag, " result code"}, {30'd0, rspOp}, {30'd0, expCode});
    check(rspData == expData, {tag, " data"}, rspData, expData);
    repeat (hold) @(posedge clk);
    #2;
    rspReady = 1'b1;
    @(posedge clk); #2;
    rspReady = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(reqReady == 1'b1, "R1 reset reqReady", {31'd0, reqReady}, 32'd1);
    check(rspValid == 1'b0, "R1 reset rspValid", {31'd0, rspValid}, 32'd0);
    check({haltReq, resumeReq, ndmReset} == 3'b000, "R4 reset outputs", {29'd0, haltReq, resumeReq, ndmReset}, 32'd0);
    @(posedge clk); #2;
    rstN = 1'b1;

    // R3 control register
    xfer(2'd1, 32'h10, 32'h0, 2'd0, 32'h0, "R3 read ctl after reset", 0);
    xfer(2'd2, 32'h10, 32'h8000_0003, 2'd0, 32'h0, "R3 write ctl", 0);
    check(haltReq && ndmReset, "R3 halt and ndm driven", {30'd0, haltReq, ndmReset}, 32'd3);
    xfer(2'd1, 32'h10, 32'h0, 2'd0, 32'h8000_0003, "R3 read ctl", 2);
    xfer(2'd2, 32'h10, 32'h0FFF_FFFD, 2'd0, 32'h0, "R3 write reserved", 0);
    xfer(2'd1, 32'h10, 32'h0, 2'd0, 32'h0000_0001, "R3 reserved read zero", 0);
    // R4 inactive clears all
    xfer(2'd2, 32'h10, 32'h8000_0003, 2'd0, 32'h0, "R4 set again", 0);
    xfer(2'd2, 32'h10, 32'hC000_0002, 2'd0, 32'h0, "R4 write inactive", 0);
    check({haltReq, resumeReq, ndmReset} == 3'b000, "R4 outputs low", {29'd0, haltReq, resumeReq, ndmReset}, 32'd0);
    xfer(2'd1, 32'h10, 32'h0, 2'd0, 32'h0, "R4 read ctl", 0);
    // R5 resume handshake
    xfer(2'd2, 32'h10, 32'h4000_0001, 2'd0, 32'h0, "R5 request resume", 0);
    xfer(2'd2, 32'h10, 32'h0000_0001, 2'd0, 32'h0, "R5 write zero keeps", 0);
    xfer(2'd1, 32'h10, 32'h0, 2'd0, 32'h4000_0001, "R5 pending readback", 3);
    check(resumeReq == 1'b1, "R5 still requested", {31'd0, resumeReq}, 32'd1);
    @(posedge clk); #2; coreResumeAck = 1'b1;
    @(posedge clk); #2; coreResumeAck = 1'b0;
    @(negedge clk);
    check(resumeReq == 1'b0, "R5 cleared by ack", {31'd0, resumeReq}, 32'd0);
    xfer(2'd1, 32'h10, 32'h0, 2'd0, 32'h0000_0001, "R5 readback after ack", 0);
    // R6 status
    coreHalted = 1'b1; coreHaveReset = 1'b1;
    xfer(2'd1, 32'h11, 32'h0, 2'd0, 32'h000C_0302, "R6 halted status", 0);
    coreHalted = 1'b0; coreRunning = 1'b1; coreHaveReset = 1'b0; coreResumeAck = 1'b1;
    xfer(2'd1, 32'h11, 32'h0, 2'd0, 32'h0003_0C02, "R6 running status", 0);
    coreResumeAck = 1'b0;
    xfer(2'd2, 32'h11, 32'hFFFF_FFFF, 2'd0, 32'h0, "R6 write ignored", 0);
    xfer(2'd1, 32'h11, 32'h0, 2'd0, 32'h0000_0C02, "R6 status after write", 0);
    // R8 hart info
    xfer(2'd1, 32'h12, 32'h0, 2'd0, 32'h0, "R8 hartinfo read", 0);
    xfer(2'd2, 32'h12, 32'h1234_5678, 2'd0, 32'h0, "R8 hartinfo write", 0);
    xfer(2'd1, 32'h12, 32'h0, 2'd0, 32'h0, "R8 hartinfo unchanged", 0);
    // R7 unmapped
    xfer(2'd1, 32'h13, 32'h0, 2'd1, 32'h0, "R7 unmapped read", 0);
    xfer(2'd2, 32'h20, 32'hFFFF_FFFF, 2'd1, 32'h0, "R7 unmapped write", 0);
    xfer(2'd2, 32'h110, 32'h8000_0003, 2'd1, 32'h0, "R7 aliased write", 0);
    xfer(2'd1, 32'h10, 32'h0, 2'd0, 32'h0000_0001, "R7 ctl untouched", 0);
    // R2 ops
    xfer(2'd3, 32'h10, 32'h8000_0003, 2'd1, 32'h0, "R2 invalid op", 0);
    xfer(2'd0, 32'h10, 32'h8000_0003, 2'd0, 32'h0, "R2 nop", 0);
    xfer(2'd1, 32'h10, 32'h0, 2'd0, 32'h0000_0001, "R2 ctl untouched", 0);
    // R9 forwarding
    absRdata = 32'hA5A5_1234;
    xfer(2'd1, 32'h04, 32'h0, 2'd0, 32'hA5A5_1234, "R9 data0 read", 0);
    xfer(2'd2, 32'h17, 32'h0010_100A, 2'd0, 32'h0, "R9 command write", 0);
    absRdata = 32'h0000_0700;
    xfer(2'd1, 32'h16, 32'h0, 2'd0, 32'h0000_0700, "R9 cmdstat read", 1);
    // R10 busy refusal
    absBusy = 1'b1; absRdata = 32'h0000_1000;
    xfer(2'd1, 32'h04, 32'h0, 2'd2, 32'h0, "R10 data0 busy", 0);
    xfer(2'd2, 32'h17, 32'h1, 2'd2, 32'h0, "R10 command busy", 0);
    xfer(2'd2, 32'h04, 32'h5, 2'd2, 32'h0, "R10 data0 write busy", 0);
    xfer(2'd1, 32'h16, 32'h0, 2'd0, 32'h0000_1000, "R10 cmdstat while busy", 0);
    absBusy = 1'b0;
    xfer(2'd1, 32'h17, 32'h0, 2'd0, 32'h0000_1000, "R10 command after busy", 0);

    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule